// File: doc/BRIEF.md
# Strobe-Handshake Shift FIFO

This block is a 64-word first-in first-out buffer. A producer moves words in with a level strobe, and a consumer moves words out with a second level strobe. Each side has a ready flag. The input ready flag tells the producer there is room, and it drops for as long as a strobe that has been taken stays high. The output ready flag tells the consumer that the word on the data outputs is valid. It drops as soon as the consumer raises its strobe, and the next word is presented only when that strobe falls. The two flags are shaped so that one unit's output ready can drive the next unit's shift-in, and its input ready can drive the previous unit's shift-out.

The model is synchronous to one clock. Both strobes pass through a configurable synchroniser and are then treated as levels. Words are held in a two-port store with wrapping pointers. A register stage in front of the pins holds the word on offer. That register is included in the 64-word capacity, so no extra entry is gained. An active-low output enable floats the data outputs. An active-low master reset empties the buffer and clears the presented word to zero.

Top module: `shift_fifo`

## Requirements
- R1: While reset is held and right after it, in_rdy is 1, out_rdy is 0 and dout (with out_en_n low) is all zeros.
- R2: When shift_in goes high and in_rdy is 1, din is stored. in_rdy then reads 0 until shift_in falls, and after that it reads 1 unless the buffer is full.
- R3: Words leave in the order they were stored.
- R4: A word stored into an empty buffer reaches dout on its own, and out_rdy then reads 1.
- R5: A rising shift_out drops out_rdy while dout keeps its value. The following word is presented, with out_rdy back at 1, only after shift_out falls.
- R6: Once the last word has been taken, dout keeps that word and out_rdy stays 0.
- R7: If shift_out is held high while the buffer is empty and a word arrives, that word reaches dout and out_rdy is high for exactly one clock. Later words do not appear until shift_out goes low.
- R8: The buffer holds 64 words. When it is full, in_rdy is 0, and a shift_in pulse has no effect on in_rdy, out_rdy or the word presented.
- R9: If shift_in is held high while the buffer is full, the word is taken once one word has been shifted out. in_rdy then stays 0 while shift_in stays high.
- R10: Asserting mrst_n low during operation discards all words at once: out_rdy goes to 0, in_rdy to 1 and dout to zeros.
- R11: If shift_in is high when reset is released, din is stored and in_rdy stays 0 until shift_in falls. If shift_in is low at release, nothing is stored.
- R12: With out_en_n high, dout is high impedance. With it low, dout drives the presented word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| shift_in | input | 1 | Write strobe level |
| din | input | DATA_W | Word to store |
| in_rdy | output | 1 | Room available / strobe accepted handshake |
| shift_out | input | 1 | Read strobe level |
| out_rdy | output | 1 | Presented word valid |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Presented word, tri-stated |

## Verification
A strobe edge reaches the control logic after two synchroniser clocks, and the flag and pointer updates land on the third clock. The in_rdy and out_rdy responses are therefore due three clocks after a strobe changes. A word stored into an empty buffer is presented one clock after that, four clocks after the shift_in rise. The bench drives on falling clock edges and waits six or more clocks after every strobe change before it samples. Reset effects are asynchronous, and the bench checks them a fraction of a clock after mrst_n falls. The one-clock out_rdy pulse of R7 is caught by a counter of rising edges sampled on falling clock edges.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;
   localparam int unsigned SF_DEPTH_DEFAULT = 64;
   localparam int unsigned SF_WIDTH_DEFAULT = 4;
   localparam int unsigned SF_SYNC_DEFAULT  = 2;

   // occupancy step: +1 on store, -1 on consume, both leaves it unchanged
   function automatic logic [7:0] occ_step(input logic [7:0] occ,
                                           input logic inc,
                                           input logic dec);
      logic [7:0] r;
      r = occ;
      if (inc && !dec) r = occ + 8'd1;
      else if (dec && !inc) r = occ - 8'd1;
      return r;
   endfunction
endpackage

// File: rtl/shift_sync.sv
module shift_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign level = async_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= async_in;
            else chain <= {chain[STAGES-2:0], async_in};
         end
         assign level = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/shift_store.sv
module shift_store #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_en) wptr <= wptr + 1'b1;
         if (rd_en) rptr <= rptr + 1'b1;
      end
   end

   assign rd_data = mem[rptr];
endmodule

// File: rtl/shift_wr_ctrl.sv
module shift_wr_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic si_hi,
   input  logic full_next,
   output logic fire,
   output logic in_rdy
);
   logic hold;

   // take the word once per high phase of the strobe, only when ready
   assign fire = si_hi && !hold && in_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold   <= 1'b0;
         in_rdy <= 1'b1;
      end else begin
         hold   <= si_hi && (hold || fire);
         in_rdy <= !full_next && !(si_hi && (hold || fire));
      end
   end

   // R2: a taken strobe keeps in_rdy low while the strobe stays high
   a_r2_ir_low_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      fire && si_hi |=> !in_rdy);
endmodule

// File: rtl/shift_rd_ctrl.sv
module shift_rd_ctrl #(
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              so_hi,
   input  logic              avail,
   input  logic [DATA_W-1:0] rd_data,
   output logic              load,
   output logic              consume,
   output logic              out_rdy,
   output logic [DATA_W-1:0] q
);
   logic spent;

   assign load    = !out_rdy && avail && !(so_hi && spent);
   assign consume = so_hi && out_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spent   <= 1'b0;
         out_rdy <= 1'b0;
         q       <= '0;
      end else begin
         spent <= so_hi && (spent || out_rdy || load);
         if (load) begin
            q       <= rd_data;
            out_rdy <= 1'b1;
         end else if (consume) begin
            out_rdy <= 1'b0;
         end
      end
   end

   // R5: the presented word only changes together with a valid flag
   a_r5_dout_moves_with_or: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(q) |-> out_rdy);
   // R7: a high read strobe never lets the flag stay up two clocks
   a_r7_or_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      so_hi && out_rdy |=> !out_rdy);
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
   import shift_fifo_pkg::*;
#(
   parameter int unsigned DEPTH       = SF_DEPTH_DEFAULT,
   parameter int unsigned DATA_W      = SF_WIDTH_DEFAULT,
   parameter int unsigned SYNC_STAGES = SF_SYNC_DEFAULT
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              shift_in,
   input  logic [DATA_W-1:0] din,
   output logic              in_rdy,
   input  logic              shift_out,
   output logic              out_rdy,
   input  logic              out_en_n,
   output logic [DATA_W-1:0] dout
);
   localparam int unsigned OCC_W = $clog2(DEPTH + 1);

   generate
      if (DATA_W < 4 || DATA_W > 5) begin : g_bad_width
         $error("shift_fifo: DATA_W must be 4 or 5");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 128) begin : g_bad_depth
         $error("shift_fifo: DEPTH must be a power of two from 2 to 128");
      end
   endgenerate

   logic              si_hi, so_hi;
   logic              fire, load, consume, full_next, avail;
   logic [DATA_W-1:0] rd_data, q;
   logic [OCC_W-1:0]  occ, occ_next;

   shift_sync #(.STAGES(SYNC_STAGES)) u_si_sync (
      .clk(clk), .rst_n(mrst_n), .async_in(shift_in), .level(si_hi));
   shift_sync #(.STAGES(SYNC_STAGES)) u_so_sync (
      .clk(clk), .rst_n(mrst_n), .async_in(shift_out), .level(so_hi));

   shift_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(mrst_n),
      .wr_en(fire), .wr_data(din),
      .rd_en(load), .rd_data(rd_data));

   shift_wr_ctrl u_wr (
      .clk(clk), .rst_n(mrst_n), .si_hi(si_hi),
      .full_next(full_next), .fire(fire), .in_rdy(in_rdy));

   shift_rd_ctrl #(.DATA_W(DATA_W)) u_rd (
      .clk(clk), .rst_n(mrst_n), .so_hi(so_hi), .avail(avail),
      .rd_data(rd_data), .load(load), .consume(consume),
      .out_rdy(out_rdy), .q(q));

   // occupancy counts stored words plus the presented word not yet taken
   always_comb begin
      logic [7:0] step;
      step      = occ_step(8'(occ), fire, consume);
      occ_next  = step[OCC_W-1:0];
      full_next = (occ_next == OCC_W'(DEPTH));
      avail     = (occ > OCC_W'(out_rdy));
   end

   always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) occ <= '0;
      else         occ <= occ_next;
   end

   assign dout = out_en_n ? {DATA_W{1'bz}} : q;

   // R8: occupancy never passes capacity
   a_r8_occ_bound: assert property (@(posedge clk) disable iff (!mrst_n)
      occ <= OCC_W'(DEPTH));
   // R8: nothing is stored while full
   a_r8_no_store_when_full: assert property (@(posedge clk) disable iff (!mrst_n)
      fire |-> occ < OCC_W'(DEPTH));
   // R8: full buffer shows no room
   a_r8_ir_low_full: assert property (@(posedge clk) disable iff (!mrst_n)
      occ == OCC_W'(DEPTH) |-> !in_rdy);
endmodule

// File: tb/shift_fifo_tb.sv
module shift_fifo_tb;
   localparam int W = 4;
   localparam int D = 64;
   localparam logic [W-1:0] MASK = {W{1'b1}};

   logic clk = 1'b0;
   logic mrst_n = 1'b0;
   logic shift_in = 1'b0, shift_out = 1'b0, out_en_n = 1'b0;
   logic [W-1:0] din = '0;
   logic in_rdy, out_rdy;
   logic [W-1:0] dout;
   int checks = 0, errors = 0;
   int or_rises = 0;
   logic or_prev = 1'b0;

   always #2 clk = ~clk;

   shift_fifo #(.DEPTH(D), .DATA_W(W)) u_dut (
      .clk(clk), .mrst_n(mrst_n), .shift_in(shift_in), .din(din),
      .in_rdy(in_rdy), .shift_out(shift_out), .out_rdy(out_rdy),
      .out_en_n(out_en_n), .dout(dout));

   always @(negedge clk) begin
      if (out_rdy === 1'b1 && or_prev !== 1'b1) or_rises++;
      or_prev = out_rdy;
   end

   function automatic logic [W-1:0] pat(input int i);
      return W'((i * 7 + 3) ^ (i >> 4)) & MASK;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [W-1:0] v);
      int t = 0;
      while (in_rdy !== 1'b1 && t < 100) begin cyc(1); t++; end
      din = v; shift_in = 1'b1; cyc(7);
      shift_in = 1'b0; cyc(7);
   endtask

   task automatic pop(input string req, input logic [W-1:0] exp);
      chk(req, W'(out_rdy), W'(1));
      chk(req, dout, exp);
      shift_out = 1'b1; cyc(7);
      chk("R5", W'(out_rdy), W'(0));
      chk("R5", dout, exp);
      shift_out = 1'b0; cyc(7);
   endtask

   task automatic do_reset;
      mrst_n = 1'b0; cyc(3); mrst_n = 1'b1; cyc(4);
   endtask

   task automatic t_reset_oe;
      cyc(2);
      chk("R1", W'(in_rdy), W'(1));
      chk("R1", W'(out_rdy), W'(0));
      chk("R1", dout, '0);
      mrst_n = 1'b1; cyc(4);
      out_en_n = 1'b1; #1;
      chk("R12", dout, {W{1'bz}});
      out_en_n = 1'b0; #1;
      chk("R12", dout, '0);
   endtask

   task automatic t_bubble_order;
      din = 4'h9; shift_in = 1'b1; cyc(7);
      chk("R2", W'(in_rdy), W'(0));
      chk("R4", W'(out_rdy), W'(1));
      chk("R4", dout, 4'h9);
      shift_in = 1'b0; cyc(7);
      chk("R2", W'(in_rdy), W'(1));
      push(4'h2); push(4'hC);
      chk("R5", dout, 4'h9);
      pop("R3", 4'h9); pop("R3", 4'h2); pop("R3", 4'hC);
      chk("R6", W'(out_rdy), W'(0));
      chk("R6", dout, 4'hC);
   endtask

   task automatic t_hold_so;
      shift_out = 1'b1; cyc(6);
      or_rises = 0;
      push(4'h5);
      chk("R7", W'(or_rises), W'(1));
      chk("R7", W'(out_rdy), W'(0));
      chk("R7", dout, 4'h5);
      push(4'hA);
      chk("R7", dout, 4'h5);
      chk("R7", W'(or_rises), W'(1));
      shift_out = 1'b0; cyc(7);
      chk("R7", W'(out_rdy), W'(1));
      pop("R7", 4'hA);
   endtask

   task automatic t_full;
      do_reset();
      for (int i = 0; i < D; i++) push(pat(i));
      chk("R8", W'(in_rdy), W'(0));
      din = pat(D); shift_in = 1'b1; cyc(8);
      chk("R8", W'(in_rdy), W'(0));
      chk("R8", W'(out_rdy), W'(1));
      chk("R8", dout, pat(0));
      shift_out = 1'b1; cyc(7);
      shift_out = 1'b0; cyc(8);
      chk("R9", W'(in_rdy), W'(0));
      chk("R9", dout, pat(1));
      shift_in = 1'b0; cyc(8);
      chk("R9", W'(in_rdy), W'(0));
      for (int i = 1; i <= D; i++) pop("R3", pat(i));
      chk("R6", W'(out_rdy), W'(0));
      chk("R9", W'(in_rdy), W'(1));
   endtask

   task automatic t_reset_cases;
      push(4'h7); push(4'h8);
      mrst_n = 1'b0; #1;
      chk("R10", W'(out_rdy), W'(0));
      chk("R10", W'(in_rdy), W'(1));
      chk("R10", dout, '0);
      din = 4'hE; shift_in = 1'b1; cyc(2);
      mrst_n = 1'b1; cyc(8);
      chk("R11", W'(out_rdy), W'(1));
      chk("R11", dout, 4'hE);
      chk("R11", W'(in_rdy), W'(0));
      shift_in = 1'b0; cyc(7);
      chk("R11", W'(in_rdy), W'(1));
      mrst_n = 1'b0; cyc(2); din = 4'h3; mrst_n = 1'b1; cyc(8);
      chk("R11", W'(in_rdy), W'(1));
      chk("R11", W'(out_rdy), W'(0));
      chk("R11", dout, '0);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset_oe();
      t_bubble_order();
      t_hold_so();
      t_full();
      t_reset_cases();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule